// File: doc/BRIEF.md
# Serial Audio Transmit Controller

This block sends audio from a processor to an external codec over a three-wire serial audio link: a bit clock, a channel select line and a data line. Software writes 32-bit sample words through a small register bus into a 32-entry queue. Each word carries one channel sample, and the words alternate left and right. Once transmission is enabled, the block sends the samples MSB first in the standard two-channel format. The channel select line changes one bit period before the first bit of each sample.

The bit rate is set outside the block. A neighbouring clock generator supplies a one-cycle `half_tick` pulse for every half period of the serial clock. Software sets the sample width as width minus one. It can queue up to 32 words before it starts a transfer, and it keeps topping the queue up while the reported fill level is below 32. When the transfer is done, software waits for the queue to empty, stops the transfer and writes to the clear register.

Top module: `aud_tx_ctrl`

## Requirements
- R1: Register word index is `bus_addr[5:2]`. Sample width control is at 0x00: bits [4:0] hold width minus one, and the reset value is 15. The transfer register is at 0x1C, with bit 0 for transmit enable and bit 1 for receive enable, and it resets to 0. Both registers read back what was written.
- R2: The slots 0x04, 0x08, 0x10, 0x14 and 0x28 always read zero, and writes to them change nothing else.
- R3: The queue holds 32 words. The register at 0x0C reports the current count in bits [5:0] and returns to 0 once transmission has drained it.
- R4: A write to the data register at 0x24 while the queue holds 32 words is discarded. It sets a sticky overflow flag, read at bit 0 of 0x18, and the discarded word is never sent.
- R5: Any write to 0x20 empties the queue and clears the overflow flag, and the serial clock is low in the next cycle.
- R6: While transmitting, each `half_tick` toggles `sck`. Data and `ws` change only on the falling edge. `ws` is low for the left channel and high for the right, and it changes on the last bit of the channel before, so the MSB of each sample follows the `ws` edge by one bit period.
- R7: Each queued word supplies one channel sample, left first. With width W, bits [W-1:0] are sent MSB first and bits above are ignored.
- R8: When the queue is empty during a transfer, zero samples are sent and `sck` keeps running.
- R9: A width written during a transfer takes effect at the next frame start. While transmission is off, it takes effect immediately.
- R10: While the transmit enable is 0, `sck`, `ws` and `sdo` are all held at 0.
- R11: The receive enable bit is stored and read back but has no effect on the serial outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| half_tick | input | 1 | Half-period pulse of the serial clock from the clock generator |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Channel select, 0 left, 1 right |
| sdo | output | 1 | Serial data |

## Verification
The assertions check on every cycle that the fill level never exceeds the depth and rises by one on an accepted push. They also check that a push into a full queue raises the overflow flag, that a clear empties the queue and drops the clock, that the outputs are quiet while transmission is off, and that `sck` moves only on `half_tick`. Only the bench's scenarios can show the serial bit order, where the channel select edge falls relative to the MSB, the zero fill on underrun, that a discarded word is never sent, and the deferred width change at a frame start. The bench checks these by capturing every rising `sck` edge and comparing against a model of the frame.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
    localparam int BUS_W     = 32;
    localparam int REG_AW    = 6;
    localparam int WIDTH_RST = 15;

    // Word index of each register slot (byte address bits [5:2]).
    typedef enum logic [3:0] {
        RG_TXCTL  = 4'h0,
        RG_RXCTL  = 4'h1,
        RG_CLKCTL = 4'h2,
        RG_LEVEL  = 4'h3,
        RG_DMACTL = 4'h4,
        RG_IRQEN  = 4'h5,
        RG_IRQST  = 4'h6,
        RG_XFER   = 4'h7,
        RG_CLEAR  = 4'h8,
        RG_TXDAT  = 4'h9,
        RG_RXDAT  = 4'hA
    } reg_idx_e;
endpackage

// File: rtl/aud_tx_fifo.sv
module aud_tx_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 32,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          full,
    output logic          empty,
    output logic [LW-1:0] level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [LW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (st_q.cnt == LW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign level   = st_q.cnt;
    assign rdata   = mem_q[st_q.rp];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wp = ptr_inc(st_q.wp);
            if (do_pop)  st_d.rp = ptr_inc(st_q.rp);
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem_q[st_q.wp] <= wdata;
    end
endmodule

// File: rtl/aud_tx_ser.sv
module aud_tx_ser #(
    parameter int DW = 32,
    parameter int WW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          clear,
    input  logic          half_tick,
    input  logic [WW-1:0] width_f,
    input  logic          fifo_empty,
    input  logic [DW-1:0] fifo_data,
    output logic          pop,
    output logic          sck,
    output logic          ws,
    output logic          sdo
);
    localparam int PW = WW + 1;

    typedef struct packed {
        logic          sck;
        logic          primed;
        logic [PW-1:0] pos;
        logic [WW-1:0] wcur;
        logic [DW-1:0] shreg;
    } ser_st_t;

    ser_st_t st_d, st_q;
    logic last_l, last_r, chan;
    logic [DW-1:0] next_word;

    // Place bit (width-1) of the sample at the top of the shift register.
    function automatic logic [DW-1:0] align(input logic [DW-1:0] w, input logic [WW-1:0] f);
        return w << (DW - 1 - int'(f));
    endfunction

    assign last_l    = (st_q.pos == {1'b0, st_q.wcur});
    assign last_r    = (st_q.pos == {st_q.wcur, 1'b1});
    assign chan      = (st_q.pos > {1'b0, st_q.wcur});
    assign next_word = fifo_empty ? '0 : fifo_data;

    always_comb begin
        st_d = st_q;
        pop  = 1'b0;
        if (clear || !en) begin
            st_d        = '0;
            st_d.wcur   = width_f;
        end else if (!st_q.primed) begin
            st_d.primed = 1'b1;
            st_d.wcur   = width_f;
            st_d.pos    = '0;
            st_d.shreg  = align(next_word, width_f);
            pop         = !fifo_empty;
        end else if (half_tick) begin
            st_d.sck = ~st_q.sck;
            if (st_q.sck) begin
                if (last_r) begin
                    st_d.pos   = '0;
                    st_d.wcur  = width_f;
                    st_d.shreg = align(next_word, width_f);
                    pop        = !fifo_empty;
                end else if (last_l) begin
                    st_d.pos   = st_q.pos + 1'b1;
                    st_d.shreg = align(next_word, st_q.wcur);
                    pop        = !fifo_empty;
                end else begin
                    st_d.pos   = st_q.pos + 1'b1;
                    st_d.shreg = st_q.shreg << 1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sck = st_q.sck;
    assign sdo = st_q.shreg[DW-1];
    assign ws  = st_q.primed && ((last_l || last_r) ? ~chan : chan);
endmodule

// File: rtl/aud_tx_ctrl.sv
module aud_tx_ctrl
    import aud_tx_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 32,
    parameter int WW    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              half_tick,
    output logic              sck,
    output logic              ws,
    output logic              sdo
);
    localparam int LW = $clog2(DEPTH) + 1;

    typedef struct packed {
        logic [WW-1:0] width;
        logic [1:0]    xfer;
        logic          ovf;
    } regs_t;

    regs_t rg_d, rg_q;
    logic [3:0]    widx;
    logic          push_req, clr_req, fifo_pop, fifo_full, fifo_empty;
    logic          tx_en, ovf_flag;
    logic [LW-1:0] fifo_level;
    logic [DW-1:0] fifo_head;

    assign widx     = bus_addr[REG_AW-1:2];
    assign push_req = bus_wr && (widx == RG_TXDAT);
    assign clr_req  = bus_wr && (widx == RG_CLEAR);
    assign tx_en    = rg_q.xfer[0];
    assign ovf_flag = rg_q.ovf;

    always_comb begin
        rg_d = rg_q;
        if (bus_wr && widx == RG_TXCTL) rg_d.width = bus_wdata[WW-1:0];
        if (bus_wr && widx == RG_XFER)  rg_d.xfer  = bus_wdata[1:0];
        if (push_req && fifo_full)      rg_d.ovf   = 1'b1;
        if (clr_req)                    rg_d.ovf   = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q       <= '0;
            rg_q.width <= WW'(WIDTH_RST);
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (widx)
            RG_TXCTL: bus_rdata[WW-1:0] = rg_q.width;
            RG_LEVEL: bus_rdata[LW-1:0] = fifo_level;
            RG_IRQST: bus_rdata[0]      = rg_q.ovf;
            RG_XFER:  bus_rdata[1:0]    = rg_q.xfer;
            default:  bus_rdata         = '0;
        endcase
    end

    aud_tx_fifo #(.DW(DW), .DEPTH(DEPTH)) fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (clr_req),
        .push  (push_req),
        .pop   (fifo_pop),
        .wdata (bus_wdata[DW-1:0]),
        .rdata (fifo_head),
        .full  (fifo_full),
        .empty (fifo_empty),
        .level (fifo_level)
    );

    aud_tx_ser #(.DW(DW), .WW(WW)) ser_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (tx_en),
        .clear      (clr_req),
        .half_tick  (half_tick),
        .width_f    (rg_q.width),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_head),
        .pop        (fifo_pop),
        .sck        (sck),
        .ws         (ws),
        .sdo        (sdo)
    );
endmodule

// File: rtl/aud_tx_chk.sv
module aud_tx_chk #(
    parameter int DEPTH = 32,
    parameter int LW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          half_tick,
    input logic          tx_en,
    input logic          clr_req,
    input logic          push_req,
    input logic          fifo_pop,
    input logic          fifo_full,
    input logic          ovf_flag,
    input logic          sck,
    input logic          ws,
    input logic          sdo,
    input logic [LW-1:0] fifo_level
);
    a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LW'(DEPTH));

    a_r3_push_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !fifo_full && !fifo_pop && !clr_req) |=> fifo_level == $past(fifo_level) + 1'b1);

    a_r4_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && fifo_full && !clr_req) |=> ovf_flag);

    a_r5_clear_resets: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (fifo_level == '0 && !ovf_flag && !sck));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (!sck && !ws && !sdo));

    a_r6_sck_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !clr_req && !half_tick) |=> $stable(sck));
endmodule

bind aud_tx_ctrl aud_tx_chk #(.DEPTH(DEPTH), .LW(LW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .half_tick  (half_tick),
    .tx_en      (tx_en),
    .clr_req    (clr_req),
    .push_req   (push_req),
    .fifo_pop   (fifo_pop),
    .fifo_full  (fifo_full),
    .ovf_flag   (ovf_flag),
    .sck        (sck),
    .ws         (ws),
    .sdo        (sdo),
    .fifo_level (fifo_level)
);

// File: tb/aud_tx_ctrl_tb_top.sv
module aud_tx_ctrl_tb_top;
    localparam logic [5:0] A_TXCTL = 6'h00, A_RXCTL = 6'h04, A_CLKCTL = 6'h08,
                           A_LEVEL = 6'h0C, A_DMACTL = 6'h10, A_IRQEN = 6'h14,
                           A_IRQST = 6'h18, A_XFER = 6'h1C, A_CLEAR = 6'h20,
                           A_TXDAT = 6'h24, A_RXDAT = 6'h28;

    logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, half_tick = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sck, ws, sdo;

    int checks = 0, fails = 0;
    logic [31:0] words [64];
    logic        obs_ws [2048];
    logic        obs_sd [2048];
    int          obs_n = 0;
    logic        cap_on = 1'b0;
    logic        sck_prev = 1'b0;

    aud_tx_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .half_tick(half_tick),
        .sck(sck), .ws(ws), .sdo(sdo)
    );

    always #4 clk = ~clk;

    initial begin
        forever begin
            repeat (2) @(posedge clk);
            #1 half_tick = 1'b1;
            @(posedge clk);
            #1 half_tick = 1'b0;
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (cap_on && sck && !sck_prev && obs_n < 2048) begin
                obs_ws[obs_n] = ws;
                obs_sd[obs_n] = sdo;
                obs_n++;
            end
            sck_prev = sck;
        end
    end

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(posedge clk);
        #1 bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(posedge clk);
        #1 bus_addr = a;
        #2 v = bus_rdata;
    endtask

    task automatic chk_reg(input logic [5:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        rd(a, v);
        chk(v == exp, req, $sformatf("read 0x%0h", a), v, exp);
    endtask

    // Push npush words; expect n accepted. Transmit frames with width w0 for
    // frame 0 and w1 afterwards (w1 written mid-frame when mid is set), then
    // one underrun frame, and compare every captured bit.
    task automatic run_stream(input int w0, input int w1, input int n,
                              input int npush, input bit mid, input string dtag);
        int total, idx, k, ws_err, dat_err, und_err;
        logic [31:0] v;
        wr(A_CLEAR, 32'h0);
        wr(A_TXCTL, 32'(w0 - 1));
        for (int i = 0; i < npush; i++) begin
            words[i] = $urandom;
            wr(A_TXDAT, words[i]);
        end
        chk_reg(A_LEVEL, 32'(n), "R3");
        chk_reg(A_IRQST, (npush > n) ? 32'h1 : 32'h0, "R4");
        total = mid ? (2 * w0 + n * w1) : ((n + 2) * w0);
        obs_n  = 0;
        cap_on = 1'b1;
        wr(A_XFER, 32'h1);
        if (mid) begin
            while (obs_n < 1) @(negedge clk);
            wr(A_TXCTL, 32'(w1 - 1));
        end
        while (obs_n < total) @(negedge clk);
        wr(A_XFER, 32'h0);
        cap_on = 1'b0;
        ws_err = 0; dat_err = 0; und_err = 0;
        idx = 0; k = 0;
        for (int f = 0; idx < total; f++) begin
            int w;
            w = (f == 0 || !mid) ? w0 : w1;
            for (int ch = 0; ch < 2; ch++) begin
                for (int b = 0; b < w; b++) begin
                    if (idx < total) begin
                        int p;
                        logic ews, esd;
                        p   = ch * w + b;
                        ews = (p == w - 1 || p == 2 * w - 1) ? logic'(ch == 0) : logic'(ch == 1);
                        esd = (k < n) ? words[k][w - 1 - b] : 1'b0;
                        if (obs_ws[idx] !== ews) ws_err++;
                        if (obs_sd[idx] !== esd) begin
                            if (k < n) dat_err++;
                            else       und_err++;
                        end
                        idx++;
                    end
                end
                k++;
            end
        end
        chk(ws_err == 0, "R6", "ws pattern mismatches", ws_err, 0);
        chk(dat_err == 0, dtag, "data bit mismatches", dat_err, 0);
        chk(und_err == 0, "R8", "underrun bits not zero", und_err, 0);
        repeat (2) @(negedge clk);
        chk({sck, ws, sdo} == 3'b000, "R10", "outputs after disable", {sck, ws, sdo}, 0);
        chk_reg(A_LEVEL, 32'h0, "R3");
        rd(A_TXCTL, v);
        chk(v == 32'((mid ? w1 : w0) - 1), "R1", "width readback", v, (mid ? w1 : w0) - 1);
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 / R10: reset state
        chk_reg(A_TXCTL, 32'd15, "R1");
        chk_reg(A_XFER, 32'h0, "R1");
        chk_reg(A_LEVEL, 32'h0, "R3");
        chk_reg(A_IRQST, 32'h0, "R4");
        @(negedge clk);
        chk({sck, ws, sdo} == 3'b000, "R10", "outputs after reset", {sck, ws, sdo}, 0);

        // R2: reserved slots
        wr(A_RXCTL, 32'hFFFF_FFFF);
        wr(A_CLKCTL, 32'hFFFF_FFFF);
        wr(A_DMACTL, 32'hFFFF_FFFF);
        wr(A_IRQEN, 32'hFFFF_FFFF);
        wr(A_RXDAT, 32'hFFFF_FFFF);
        chk_reg(A_RXCTL, 32'h0, "R2");
        chk_reg(A_CLKCTL, 32'h0, "R2");
        chk_reg(A_DMACTL, 32'h0, "R2");
        chk_reg(A_IRQEN, 32'h0, "R2");
        chk_reg(A_RXDAT, 32'h0, "R2");
        chk_reg(A_TXCTL, 32'd15, "R2");
        chk_reg(A_XFER, 32'h0, "R2");

        // R11: receive enable alone does nothing on the serial side
        wr(A_XFER, 32'h2);
        chk_reg(A_XFER, 32'h2, "R11");
        begin
            int moved;
            moved = 0;
            repeat (30) begin
                @(negedge clk);
                if (sck || ws || sdo) moved++;
            end
            chk(moved == 0, "R11", "serial activity with rx only", moved, 0);
        end
        wr(A_XFER, 32'h0);

        // R6/R7/R8: directed widths
        run_stream(16, 16, 8, 8, 1'b0, "R7");
        run_stream(24, 24, 6, 6, 1'b0, "R7");

        // R9: width change mid-frame applies from frame 1
        run_stream(16, 24, 8, 8, 1'b1, "R9");

        // R4: overflow drops the 33rd word
        run_stream(8, 8, 32, 33, 1'b0, "R4");

        // R5: clear flushes queue and overflow flag
        wr(A_CLEAR, 32'h0);
        for (int i = 0; i < 33; i++) wr(A_TXDAT, $urandom);
        chk_reg(A_IRQST, 32'h1, "R4");
        wr(A_CLEAR, 32'h0);
        chk_reg(A_LEVEL, 32'h0, "R5");
        chk_reg(A_IRQST, 32'h0, "R5");

        // Random streams
        for (int it = 0; it < 4; it++) begin
            int w, n;
            w = 8 * (1 + int'($urandom % 4));
            n = 2 * (1 + int'($urandom % 16));
            run_stream(w, w, n, n, 1'b0, "R7");
        end

        summary();
        $finish;
    end
endmodule